// File: doc/BRIEF.md
# Periodic Battery Load-Test Sequencer

This block decides when a backup battery is put under load and whether it is still healthy. It counts a one-pulse-per-second time base. A short recovery delay after main power becomes good, it connects an external load resistor for a fixed window. During that window it reads an external comparator that reports the battery as below its trip point. After that first test it repeats the test once every day, as long as main power stays good.

A failed test latches a warning. The warning drives an open-drain, active-low pin, so the block only ever enables a pull-down. The warning does not clear by itself. While it is set, the daily tests are skipped. Only two things can clear it: a test after a power-up that passes, or a pulse saying the battery has been swapped. A swap pulse also starts a new test at once. A passing test restarts the daily count from zero. While main power is bad, nothing is counted and the load stays off.

Top module: `battery_monitor`

## Requirements
- R1: Under reset, `load_en` is 0 and `warn_pull` is 0.
- R2: Once a test starts, `load_en` stays 1 for exactly `TEST_S` time-base pulses. It drops in the cycle after the last of those pulses.
- R3: With the default sampling mode, `batt_low` = 1 (1 means the battery is below the trip point) is sampled on each time-base pulse while the load is connected. A 1 on any of those pulses sets the warning, so `warn_pull` = 1 when the window closes. A window with no 1 leaves the warning at 0.
- R4: While the warning is set, daily boundaries do not connect the load, and `warn_pull` stays 1.
- R5: After `pwr_good` rises, the first test starts on the `RECOV_S`-th time-base pulse. It runs even when the warning is set. If it passes, the warning clears.
- R6: After a test window closes, the next test starts on the `PERIOD_S`-th time-base pulse. The default is 86400.
- R7: While `pwr_good` is 0:
  - `load_en` is 0 from the next cycle on, and the counts restart on the next power-up.
  - `warn_pull` is 0, but the latched warning is kept and shows again when power returns.
- R8: A `batt_swap` pulse while `pwr_good` is 1 does three things:
  - it clears the warning in the next cycle;
  - it connects the load in that same cycle;
  - it restarts the daily count from that test.
- R9: A `batt_swap` pulse while `pwr_good` is 0 is ignored, and the warning is still set when power returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| pwr_good | input | 1 | Main supply within tolerance |
| batt_low | input | 1 | Comparator result: 1 = battery below the trip point |
| batt_swap | input | 1 | One-cycle pulse when a new battery is fitted |
| load_en | output | 1 | Connects the test load to the battery |
| warn_pull | output | 1 | Pull-down enable of the open-drain warning pin (1 = pin driven low) |

## Verification
The assertions assume that `tick_1hz` and `batt_swap` are single-cycle pulses. They also assume that a swap pulse never shares a cycle with a time-base pulse, so that each change of `load_en` or of the warning has exactly one cause in the cycle before. The bench therefore drives every time-base pulse for one clock with idle cycles after it, and drives each swap pulse on its own clock with no tick present. `batt_low` is changed only between pulses.

// File: rtl/bmon_pkg.sv
package bmon_pkg;
   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_RECOV = 2'd1,
      ST_LOAD  = 2'd2,
      ST_IDLE  = 2'd3
   } bmon_state_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/bmon_timer.sv
module bmon_timer #(
   parameter int unsigned W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (adv) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/bmon_seq.sv
module bmon_seq
   import bmon_pkg::*;
#(
   parameter int unsigned W        = 17,
   parameter int unsigned RECOV_S  = 2,
   parameter int unsigned TEST_S   = 1,
   parameter int unsigned PERIOD_S = 86400
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwr_good,
   input  logic         tick,
   input  logic         swap,
   input  logic         warn,
   input  logic [W-1:0] cnt,
   output bmon_state_e  state_q,
   output logic         cnt_clr,
   output logic         cnt_adv,
   output logic         win_close
);
   localparam logic [W-1:0] RECOV_LAST  = W'(RECOV_S - 1);
   localparam logic [W-1:0] TEST_LAST   = W'(TEST_S - 1);
   localparam logic [W-1:0] PERIOD_LAST = W'(PERIOD_S - 1);

   bmon_state_e state_d;

   always_comb begin
      state_d   = state_q;
      cnt_clr   = 1'b0;
      cnt_adv   = 1'b0;
      win_close = 1'b0;
      if (!pwr_good) begin
         state_d = ST_OFF;
         cnt_clr = 1'b1;
      end else begin
         unique case (state_q)
            ST_OFF: begin
               state_d = ST_RECOV;
               cnt_clr = 1'b1;
            end
            ST_RECOV: begin
               if (swap) begin
                  state_d = ST_LOAD;
                  cnt_clr = 1'b1;
               end else if (tick) begin
                  if (cnt == RECOV_LAST) begin
                     state_d = ST_LOAD;
                     cnt_clr = 1'b1;
                  end else begin
                     cnt_adv = 1'b1;
                  end
               end
            end
            ST_LOAD: begin
               if (swap) begin
                  cnt_clr = 1'b1;
               end else if (tick) begin
                  if (cnt == TEST_LAST) begin
                     state_d   = ST_IDLE;
                     cnt_clr   = 1'b1;
                     win_close = 1'b1;
                  end else begin
                     cnt_adv = 1'b1;
                  end
               end
            end
            ST_IDLE: begin
               if (swap) begin
                  state_d = ST_LOAD;
                  cnt_clr = 1'b1;
               end else if (tick) begin
                  if (cnt == PERIOD_LAST) begin
                     cnt_clr = 1'b1;
                     if (!warn) state_d = ST_LOAD;
                  end else begin
                     cnt_adv = 1'b1;
                  end
               end
            end
            default: state_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_OFF;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/bmon_verdict.sv
module bmon_verdict #(
   parameter bit LAST_ONLY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_load,
   input  logic tick,
   input  logic batt_low,
   input  logic win_close,
   input  logic clear_req,
   output logic warn_q
);
   logic fail_now;

   generate
      if (LAST_ONLY) begin : g_last
         assign fail_now = batt_low;
      end else begin : g_any
         logic fail_acc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     fail_acc <= 1'b0;
            else if (!in_load || clear_req) fail_acc <= 1'b0;
            else if (tick && batt_low)      fail_acc <= 1'b1;
         end
         assign fail_now = fail_acc | batt_low;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         warn_q <= 1'b0;
      else if (clear_req) warn_q <= 1'b0;
      else if (win_close) warn_q <= fail_now;
   end
endmodule

// File: rtl/battery_monitor.sv
module battery_monitor
   import bmon_pkg::*;
#(
   parameter int unsigned RECOV_S   = 2,
   parameter int unsigned TEST_S    = 1,
   parameter int unsigned PERIOD_S  = 86400,
   parameter bit          LAST_ONLY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1hz,
   input  logic pwr_good,
   input  logic batt_low,
   input  logic batt_swap,
   output logic load_en,
   output logic warn_pull
);
   localparam int unsigned MAXV  = max3(RECOV_S, TEST_S, PERIOD_S);
   localparam int unsigned CNT_W = $clog2(MAXV + 1);

   generate
      if (RECOV_S < 1 || TEST_S < 1) begin : g_bad_len
         $error("battery_monitor: RECOV_S and TEST_S must be at least 1");
      end
      if (PERIOD_S <= TEST_S) begin : g_bad_period
         $error("battery_monitor: PERIOD_S must exceed TEST_S");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             cnt_clr, cnt_adv, win_close, warn_q, clear_req;
   bmon_state_e      state_q;

   assign clear_req = batt_swap & pwr_good;

   bmon_timer #(.W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .adv   (cnt_adv),
      .cnt   (cnt)
   );

   bmon_seq #(
      .W        (CNT_W),
      .RECOV_S  (RECOV_S),
      .TEST_S   (TEST_S),
      .PERIOD_S (PERIOD_S)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_good  (pwr_good),
      .tick      (tick_1hz),
      .swap      (batt_swap),
      .warn      (warn_q),
      .cnt       (cnt),
      .state_q   (state_q),
      .cnt_clr   (cnt_clr),
      .cnt_adv   (cnt_adv),
      .win_close (win_close)
   );

   bmon_verdict #(.LAST_ONLY(LAST_ONLY)) u_verdict (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_load   (state_q == ST_LOAD),
      .tick      (tick_1hz),
      .batt_low  (batt_low),
      .win_close (win_close),
      .clear_req (clear_req),
      .warn_q    (warn_q)
   );

   assign load_en   = (state_q == ST_LOAD);
   assign warn_pull = warn_q & pwr_good;
endmodule

// File: rtl/bmon_chk.sv
module bmon_chk #(
   parameter int unsigned TEST_S = 1
) (
   input logic clk,
   input logic rst_n,
   input logic tick_1hz,
   input logic pwr_good,
   input logic batt_swap,
   input logic load_en,
   input logic warn_pull
);
   int unsigned win_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    win_ticks <= 0;
      else if (!load_en || batt_swap) win_ticks <= 0;
      else if (tick_1hz)              win_ticks <= win_ticks + 1;
   end

   AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> (win_ticks < TEST_S)); // R2

   AST_LOAD_OFF_NO_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> !load_en); // R7

   AST_LOAD_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_en) |-> ($past(tick_1hz) || $past(batt_swap))); // R5

   AST_WARN_SET_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(warn_pull) && $past(pwr_good)) |-> ($past(load_en) && !load_en)); // R3

   AST_WARN_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(warn_pull) && $past(pwr_good) && pwr_good) |->
         ($past(batt_swap) || ($past(load_en) && !load_en))); // R8
endmodule

bind battery_monitor bmon_chk #(.TEST_S(TEST_S)) u_bmon_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_1hz  (tick_1hz),
   .pwr_good  (pwr_good),
   .batt_swap (batt_swap),
   .load_en   (load_en),
   .warn_pull (warn_pull)
);

// File: tb/tb_battery_monitor.sv
`timescale 1ns/1ps
module tb_battery_monitor;
   localparam int RECOV = 3;
   localparam int TWIN  = 2;
   localparam int DAY   = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_1hz = 1'b0, pwr_good = 1'b0, batt_low = 1'b0, batt_swap = 1'b0;
   logic load_en, warn_pull;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   battery_monitor #(.RECOV_S(RECOV), .TEST_S(TWIN), .PERIOD_S(DAY)) dut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_good(pwr_good),
      .batt_low(batt_low), .batt_swap(batt_swap), .load_en(load_en), .warn_pull(warn_pull)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic pulse_tick();
      @(negedge clk) tick_1hz = 1'b1;
      @(negedge clk) tick_1hz = 1'b0;
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) pulse_tick();
   endtask

   task automatic swap_pulse();
      @(negedge clk) batt_swap = 1'b1;
      @(negedge clk) batt_swap = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 load", load_en, 1'b0);
      check("R1 warn", warn_pull, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_powerup_pass();
      pwr_good = 1'b1;
      @(negedge clk);
      ticks(RECOV - 1);
      check("R5 before delay", load_en, 1'b0);
      ticks(1);
      check("R5 test starts", load_en, 1'b1);
      ticks(TWIN - 1);
      check("R2 window held", load_en, 1'b1);
      ticks(1);
      check("R2 window closed", load_en, 1'b0);
      check("R3 pass no warn", warn_pull, 1'b0);
   endtask

   task automatic t_daily_fail();
      ticks(DAY - 1);
      check("R6 before day", load_en, 1'b0);
      ticks(1);
      check("R6 daily test", load_en, 1'b1);
      batt_low = 1'b1;
      ticks(TWIN);
      batt_low = 1'b0;
      check("R2 daily closed", load_en, 1'b0);
      check("R3 warn set", warn_pull, 1'b1);
   endtask

   task automatic t_sticky();
      for (int i = 0; i < 2 * DAY; i++) begin
         ticks(1);
         check("R4 no load", load_en, 1'b0);
      end
      check("R4 warn held", warn_pull, 1'b1);
   endtask

   task automatic t_power_cycle();
      pwr_good = 1'b0;
      repeat (2) @(negedge clk);
      check("R7 pull released", warn_pull, 1'b0);
      ticks(5);
      check("R7 no load off", load_en, 1'b0);
      pwr_good = 1'b1;
      @(negedge clk);
      check("R7 warn kept", warn_pull, 1'b1);
      ticks(RECOV);
      check("R5 test despite warn", load_en, 1'b1);
      ticks(TWIN);
      check("R5 pass clears", warn_pull, 1'b0);
   endtask

   task automatic t_fail_mid_and_any();
      ticks(DAY);
      check("R6 next day", load_en, 1'b1);
      ticks(1);
      pwr_good = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R7 load dropped", load_en, 1'b0);
      pwr_good = 1'b1;
      @(negedge clk);
      ticks(RECOV);
      check("R5 retest", load_en, 1'b1);
      batt_low = 1'b1;
      ticks(1);
      batt_low = 1'b0;
      ticks(TWIN - 1);
      check("R3 first-pulse fail", warn_pull, 1'b1);
      check("R2 closed", load_en, 1'b0);
   endtask

   task automatic t_swap();
      ticks(4);
      swap_pulse();
      check("R8 warn cleared", warn_pull, 1'b0);
      check("R8 load at once", load_en, 1'b1);
      ticks(TWIN);
      check("R8 test done", load_en, 1'b0);
      check("R8 pass", warn_pull, 1'b0);
      ticks(DAY - 1);
      check("R8 before restart day", load_en, 1'b0);
      ticks(1);
      check("R8 day restarted", load_en, 1'b1);
      ticks(TWIN);
   endtask

   task automatic t_swap_off();
      ticks(DAY);
      check("R6 test", load_en, 1'b1);
      batt_low = 1'b1;
      ticks(TWIN);
      batt_low = 1'b0;
      check("R3 warn again", warn_pull, 1'b1);
      pwr_good = 1'b0;
      @(negedge clk);
      swap_pulse();
      @(negedge clk);
      pwr_good = 1'b1;
      @(negedge clk);
      check("R9 warn survives", warn_pull, 1'b1);
      check("R9 no load", load_en, 1'b0);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_powerup_pass();
      t_daily_fail();
      t_sticky();
      t_power_cycle();
      t_fail_mid_and_any();
      t_swap();
      t_swap_off();
      summary();
   end

   initial begin
      #2000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
   end
endmodule